// File: doc/BRIEF.md
# Call-Return and Interrupt Stack Unit

This unit decides where a small processor fetches next whenever control flow goes through a subroutine or an interrupt. On a call, it pushes the program counter supplied by the core onto an internal return-address stack and redirects the core to the call target. On a return, it pops the most recently saved address and redirects the core there. An interrupt request is handled as a call forced by hardware. The unit saves the current program counter on the same stack, redirects the core to a handler address fixed for each source, and masks further requests until an interrupt-return command.

Redirection is reported one clock after the command through a registered next-PC value and a one-cycle load strobe. The stack holds a fixed number of entries, so this number sets the maximum nesting depth. An attempt to push onto a full stack, or to pop from an empty one, sets a sticky error flag and has no other effect.

A two-state controller sequences the work. In RUN, the unit accepts commands by priority: call first, then return or interrupt-return, then an unmasked interrupt. The transition RUN→DEFER happens when a call is accepted while an unmasked request is present. DEFER→RUN always happens after one cycle, and in that cycle the held-off interrupt is entered with the call target as its saved address.

Top module: `retstack_ctrl`

## Requirements
- R1: After reset, pc_load_o, irq_mask_o, ovf_o and unf_o are 0 and the stack is empty.
- R2: A call accepted in cycle n pushes pc_i and, in cycle n+1, drives pc_load_o high for one cycle with next_pc_o equal to target_i.
- R3: A return or interrupt-return pops the newest entry and loads it into next_pc_o one cycle later, so saved addresses come back in last-in first-out order.
- R4: The stack holds DEPTH entries (8 by default). A call or interrupt entry on a full stack sets ovf_o, produces no load and leaves the stack contents unchanged.
- R5: A return or interrupt-return on an empty stack sets unf_o and produces no load.
- R6: ovf_o and unf_o stay high until reset.
- R7: An unmasked request on irq_i pushes pc_i, loads the handler address of the lowest-numbered active source i, which is 4*(i+1), and sets irq_mask_o.
- R8: While irq_mask_o is high, requests are not entered. A plain return leaves the mask unchanged, and an interrupt-return that pops clears it.
- R9: A call takes priority over a return, and a return takes priority over an interrupt. When a call and an unmasked request arrive together, the call completes first. In the next cycle (DEFER), the interrupt is entered with target_i as its saved address, and any command in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Subroutine call command |
| ret_i | input | 1 | Plain return command |
| iret_i | input | 1 | Return from interrupt handler |
| target_i | input | PC_W | Call target address |
| pc_i | input | PC_W | Address to save on call or interrupt |
| irq_i | input | N_IRQ | Interrupt request lines, index 0 highest priority |
| next_pc_o | output | PC_W | Redirect address |
| pc_load_o | output | 1 | One-cycle strobe: load next_pc_o |
| irq_mask_o | output | 1 | Interrupt mask in effect |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
The bench uses the default build: PC_W=16, DEPTH=8 and N_IRQ=4. With eight entries, filling the stack to overflow and draining it to underflow takes only a few dozen cycles, so both error edges and full last-in first-out order are checked on every run. With four request lines, all fifteen non-zero request patterns are swept, and each expected handler address is computed arithmetically from the lowest set bit.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
    typedef enum logic [0:0] {
        S_RUN   = 1'b0,
        S_DEFER = 1'b1
    } rsu_state_e;
endpackage

// File: rtl/rsu_lifo.sv
module rsu_lifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] cnt;
    logic [PW-1:0] top_idx;

    assign top_idx = cnt - PW'(1);
    assign rdata   = mem[top_idx[AW-1:0]];
    assign full    = (cnt == PW'(DEPTH));
    assign empty   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (push) cnt <= cnt + PW'(1);
        else if (pop) cnt <= cnt - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (push) mem[cnt[AW-1:0]] <= wdata;
    end

    // R4: the controller never pushes into a full stack
    p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));
    // R5: the controller never pops an empty stack
    p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
    // R3: push and pop are never requested together
    p_push_pop_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    // R2: each push raises the occupancy by one
    p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (cnt == $past(cnt) + PW'(1)));
endmodule

// File: rtl/rsu_irq_pick.sv
module rsu_irq_pick #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] vec
);
    logic [W-1:0] vec_tab [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_vec
            assign vec_tab[g] = W'((g + 1) * 4);
        end
    endgenerate

    always_comb begin
        any = 1'b0;
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                vec = vec_tab[i];
            end
        end
    end

    // R7: source 0 always wins when active
    always_comb begin
        if (req[0]) p_src0_wins_r7: assert (vec == W'(4));
    end
endmodule

// File: rtl/retstack_ctrl.sv
module retstack_ctrl
    import rsu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    parameter int N_IRQ = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              iret_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [N_IRQ-1:0]  irq_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              pc_load_o,
    output logic              irq_mask_o,
    output logic              ovf_o,
    output logic              unf_o
);
    rsu_state_e state_q, state_d;

    logic            push, pop, full, empty;
    logic [PC_W-1:0] wdata, top_data;
    logic            pick_any;
    logic [PC_W-1:0] pick_vec;
    logic            irq_ok;

    logic            load_d;
    logic [PC_W-1:0] load_val;
    logic            mask_set, mask_clr, ovf_set, unf_set;
    logic [PC_W-1:0] defer_pc_q, defer_pc_d;
    logic [PC_W-1:0] defer_vec_q, defer_vec_d;

    rsu_lifo #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (wdata),
        .rdata (top_data),
        .full  (full),
        .empty (empty)
    );

    rsu_irq_pick #(.N(N_IRQ), .W(PC_W)) u_pick (
        .req (irq_i),
        .any (pick_any),
        .vec (pick_vec)
    );

    assign irq_ok = pick_any && !irq_mask_o;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_RUN;
            defer_pc_q  <= '0;
            defer_vec_q <= '0;
        end else begin
            state_q     <= state_d;
            defer_pc_q  <= defer_pc_d;
            defer_vec_q <= defer_vec_d;
        end
    end

    // Next state and actions
    always_comb begin
        state_d     = state_q;
        push        = 1'b0;
        pop         = 1'b0;
        wdata       = pc_i;
        load_d      = 1'b0;
        load_val    = next_pc_o;
        mask_set    = 1'b0;
        mask_clr    = 1'b0;
        ovf_set     = 1'b0;
        unf_set     = 1'b0;
        defer_pc_d  = defer_pc_q;
        defer_vec_d = defer_vec_q;
        unique case (state_q)
            S_RUN: begin
                if (call_i) begin
                    if (full) begin
                        ovf_set = 1'b1;
                    end else begin
                        push     = 1'b1;
                        load_d   = 1'b1;
                        load_val = target_i;
                        if (irq_ok) begin
                            state_d     = S_DEFER;
                            defer_pc_d  = target_i;
                            defer_vec_d = pick_vec;
                        end
                    end
                end else if (ret_i || iret_i) begin
                    if (empty) begin
                        unf_set = 1'b1;
                    end else begin
                        pop      = 1'b1;
                        load_d   = 1'b1;
                        load_val = top_data;
                        mask_clr = iret_i;
                    end
                end else if (irq_ok) begin
                    if (full) begin
                        ovf_set = 1'b1;
                    end else begin
                        push     = 1'b1;
                        load_d   = 1'b1;
                        load_val = pick_vec;
                        mask_set = 1'b1;
                    end
                end
            end
            S_DEFER: begin
                state_d = S_RUN;
                if (full) begin
                    ovf_set = 1'b1;
                end else begin
                    push     = 1'b1;
                    wdata    = defer_pc_q;
                    load_d   = 1'b1;
                    load_val = defer_vec_q;
                    mask_set = 1'b1;
                end
            end
            default: state_d = S_RUN;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o  <= '0;
            pc_load_o  <= 1'b0;
            irq_mask_o <= 1'b0;
            ovf_o      <= 1'b0;
            unf_o      <= 1'b0;
        end else begin
            pc_load_o <= load_d;
            if (load_d) next_pc_o <= load_val;
            if (mask_set) irq_mask_o <= 1'b1;
            else if (mask_clr) irq_mask_o <= 1'b0;
            if (ovf_set) ovf_o <= 1'b1;
            if (unf_set) unf_o <= 1'b1;
        end
    end

    // R2: an accepted call redirects to its target one cycle later
    p_call_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && call_i && !full) |=>
        (pc_load_o && next_pc_o == $past(target_i)));
    // R6: error flags are sticky
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);
    // R8: only an interrupt-return can drop the mask
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask_o && !iret_i) |=> irq_mask_o);
    // R9: the deferred cycle enters the handler with the mask set
    p_defer_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEFER && !full) |=> (pc_load_o && irq_mask_o));
endmodule

// File: tb/retstack_ctrl_tb.sv
`timescale 1ns/1ps
module retstack_ctrl_tb;
    localparam int PC_W = 16;
    localparam int DEPTH = 8;
    localparam int N_IRQ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic call_i = 1'b0, ret_i = 1'b0, iret_i = 1'b0;
    logic [PC_W-1:0] target_i = '0, pc_i = '0;
    logic [N_IRQ-1:0] irq_i = '0;
    logic [PC_W-1:0] next_pc_o;
    logic pc_load_o, irq_mask_o, ovf_o, unf_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    retstack_ctrl #(.PC_W(PC_W), .DEPTH(DEPTH), .N_IRQ(N_IRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .iret_i(iret_i),
        .target_i(target_i), .pc_i(pc_i), .irq_i(irq_i), .next_pc_o(next_pc_o),
        .pc_load_o(pc_load_o), .irq_mask_o(irq_mask_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample just after the capturing edge
    task automatic cyc(input logic c, input logic r, input logic ir,
                       input int tgt, input int pc, input int irq);
        call_i = c; ret_i = r; iret_i = ir;
        target_i = PC_W'(tgt); pc_i = PC_W'(pc); irq_i = N_IRQ'(irq);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    function automatic int vec_of(input int pat);
        for (int i = 0; i < N_IRQ; i++)
            if (pat[i]) return 4 * (i + 1);
        return 0;
    endfunction

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        do_reset();
        chk("R1 load", pc_load_o, 0);
        chk("R1 mask", irq_mask_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 unf", unf_o, 0);

        // Fill the stack
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1, 0, 0, 'h1000 + i, 'h2000 + 3 * i, 0);
            chk("R2 load", pc_load_o, 1);
            chk("R2 target", next_pc_o, 'h1000 + i);
        end
        cyc(1, 0, 0, 'h1fff, 'h2fff, 0);
        chk("R4 no load on full", pc_load_o, 0);
        chk("R4 ovf", ovf_o, 1);
        // Drain in LIFO order; top must be untouched by the rejected push
        for (int i = DEPTH - 1; i >= 0; i--) begin
            cyc(0, 1, 0, 0, 0, 0);
            chk("R3 load", pc_load_o, 1);
            chk("R3 lifo", next_pc_o, 'h2000 + 3 * i);
        end
        cyc(0, 1, 0, 0, 0, 0);
        chk("R5 no load on empty", pc_load_o, 0);
        chk("R5 unf", unf_o, 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R6 ovf sticky", ovf_o, 1);
        chk("R6 unf sticky", unf_o, 1);
        do_reset();
        chk("R1 ovf cleared", ovf_o, 0);
        chk("R1 unf cleared", unf_o, 0);

        // All request patterns
        for (int p = 1; p < (1 << N_IRQ); p++) begin
            cyc(0, 0, 0, 0, 'h3000 + p, p);
            chk("R7 load", pc_load_o, 1);
            chk("R7 vector", next_pc_o, vec_of(p));
            chk("R7 mask", irq_mask_o, 1);
            cyc(0, 0, 1, 0, 0, p);
            chk("R8 iret addr", next_pc_o, 'h3000 + p);
            chk("R8 iret unmask", irq_mask_o, 0);
        end

        // Masking and plain return
        cyc(0, 0, 0, 0, 'h4000, 2);
        chk("R7 vec src1", next_pc_o, 8);
        cyc(0, 0, 0, 0, 'h4010, 1);
        chk("R8 masked no load", pc_load_o, 0);
        cyc(1, 0, 0, 'h5000, 'h4100, 1);
        chk("R2 nested call", next_pc_o, 'h5000);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R8 ret addr", next_pc_o, 'h4100);
        chk("R8 ret keeps mask", irq_mask_o, 1);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R8 iret addr", next_pc_o, 'h4000);
        chk("R8 iret clears", irq_mask_o, 0);

        // Call with simultaneous request
        cyc(1, 0, 0, 'h6000, 'h6100, 8);
        chk("R9 call first", next_pc_o, 'h6000);
        chk("R9 mask after call", irq_mask_o, 0);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R9 deferred load", pc_load_o, 1);
        chk("R9 deferred vector", next_pc_o, 16);
        chk("R9 deferred mask", irq_mask_o, 1);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R9 saved target", next_pc_o, 'h6000);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R9 ret ignored in defer", next_pc_o, 'h6100);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R9 stack empty after", pc_load_o, 0);

        // Return beats a request
        cyc(1, 0, 0, 'h7000, 'h7100, 0);
        cyc(0, 1, 0, 0, 'h7000, 4);
        chk("R9 ret wins", next_pc_o, 'h7100);
        chk("R9 ret wins mask", irq_mask_o, 0);
        cyc(0, 0, 0, 0, 'h7200, 4);
        chk("R9 irq next", next_pc_o, 12);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R9 irq saved pc", next_pc_o, 'h7200);
        chk("R5 no underflow so far", unf_o, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule